// File: doc/BRIEF.md
# Dual-Mode Phase-Frequency and Lock Detector

This block compares two divided pulse trains, a reference train and a feedback train, and reports their phase and frequency error. A rising edge on either input arms a flag for that side. When both flags are armed, they stay armed together for a short, fixed number of system clocks and are then cleared together. This coincident interval removes the dead zone: every comparison gives at least a minimum-width pulse on both sides, so very small phase errors still produce a response.

The flags drive one of two output styles, chosen by a mode bit. The first is a single-ended three-state error output, modelled as an enable and data pair. The second is a pair of active-low pump outputs. A polarity bit inverts the single-ended level or swaps the two pumps. A gated lock indicator stays high while the loop is matched and drops low whenever exactly one side is armed.

A reload strobe from the divider logic clears the detector, so that newly loaded counters start from a clean comparison. Everything is synchronous to one system clock, and the pulse inputs are sampled on that clock.

Top module: `pfd_lock_top`

## Requirements
- R1: While and directly after synchronous reset, neither flag is armed: se_oe=0, se_data=0, both pumps high, and lock_out equals lock_en.
- R2: A flag is armed only by a 0-to-1 change of its sampled input (ref_pulse for the reference side, fb_pulse for the feedback side). An input held high arms its flag once.
- R3: Once both flags are armed, both stay armed for exactly CLR_DELAY cycles (default 2) and are then cleared together. A single armed flag stays armed until the other side arrives.
- R4: With single_sel=1 and pol_inv=0: feedback-only gives se_oe=1 and se_data=0, reference-only gives se_oe=1 and se_data=1, and none or both gives se_oe=0 and se_data=0.
- R5: With single_sel=1 and pol_inv=1, se_data is inverted while se_oe=1. se_oe is unchanged.
- R6: With single_sel=0 and pol_inv=0: pump_fb_n is low exactly while the feedback flag is armed, and pump_ref_n is low exactly while the reference flag is armed. Both are low during the coincident interval.
- R7: With single_sel=0 and pol_inv=1, the pumps swap roles: pump_ref_n follows the feedback flag and pump_fb_n follows the reference flag.
- R8: single_sel=1 holds both pumps high. single_sel=0 holds se_oe=0 and se_data=0.
- R9: With lock_en=1, lock_out is low exactly while one flag is armed and the other is not. It stays high when neither flag is armed and during the coincident interval.
- R10: With lock_en=0, lock_out is low at all times.
- R11: reload clears both flags and the coincidence timer at the next edge. A pulse edge sampled at that same edge is discarded.
- R12: An edge that arrives at the edge where a coincident pair is cleared arms its flag afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_pulse | input | 1 | Divided reference pulse train |
| fb_pulse | input | 1 | Divided feedback pulse train |
| reload | input | 1 | Counter reload strobe; clears the detector |
| single_sel | input | 1 | 1 selects the single-ended output, 0 selects the pump pair |
| pol_inv | input | 1 | Polarity: inverts the single-ended level or swaps the pumps |
| lock_en | input | 1 | Enables the lock indicator |
| se_oe | output | 1 | Drive enable of the single-ended output (0 = high impedance) |
| se_data | output | 1 | Level of the single-ended output while enabled |
| pump_ref_n | output | 1 | Active-low pump, reference side |
| pump_fb_n | output | 1 | Active-low pump, feedback side |
| lock_out | output | 1 | Lock indicator, low pulses while the inputs disagree |

## Verification
A pulse sampled at clock edge k arms its flag in the state after edge k. All outputs follow the flags and the configuration without any further register, so every result is due in the cycle that starts at edge k. A coincident pair that begins in cycle m is visible in cycles m through m+CLR_DELAY-1 and is gone in cycle m+CLR_DELAY. The bench drives its inputs on the falling edge, checks the outputs on the next falling edge, and computes the expected armed interval of each side from the two edge times.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef struct packed {
        logic single_sel;
        logic pol_inv;
        logic lock_en;
    } pfd_cfg_t;

    typedef struct packed {
        logic fb_arm;
        logic ref_arm;
    } pfd_flags_t;

    typedef enum logic [1:0] {
        CMP_IDLE     = 2'b00,
        CMP_REF_LEAD = 2'b01,
        CMP_FB_LEAD  = 2'b10,
        CMP_COINCIDE = 2'b11
    } pfd_cmp_e;

    localparam int unsigned NUM_SIDES = 2;
    localparam int unsigned SIDE_REF  = 0;
    localparam int unsigned SIDE_FB   = 1;

    function automatic pfd_cmp_e classify(input pfd_flags_t f);
        unique case ({f.fb_arm, f.ref_arm})
            2'b00:   return CMP_IDLE;
            2'b01:   return CMP_REF_LEAD;
            2'b10:   return CMP_FB_LEAD;
            default: return CMP_COINCIDE;
        endcase
    endfunction

    function automatic logic is_one_sided(input pfd_cmp_e c);
        return (c == CMP_REF_LEAD) || (c == CMP_FB_LEAD);
    endfunction

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= din;
    end

    assign rise = din & ~prev_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
#(
    parameter int unsigned CLR_DELAY = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reload,
    input  logic [NUM_SIDES-1:0] pulse_in,
    output pfd_flags_t           flags
);
    localparam int unsigned CW = (CLR_DELAY < 2) ? 1 : $clog2(CLR_DELAY + 1);
    localparam logic [CW-1:0] LAST = CW'(CLR_DELAY - 1);

    logic [NUM_SIDES-1:0] rise;
    logic [NUM_SIDES-1:0] arm_q;
    logic [CW-1:0]        hold_q;
    logic                 both;
    logic                 clear;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        pfd_edge_det u_edge (
            .clk  (clk),
            .rst  (rst),
            .din  (pulse_in[s]),
            .rise (rise[s])
        );
    end

    assign both  = &arm_q;
    assign clear = both && (hold_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            arm_q  <= '0;
            hold_q <= '0;
        end else begin
            arm_q  <= (arm_q & ~{NUM_SIDES{clear}}) | rise;
            hold_q <= (both && !clear) ? hold_q + 1'b1 : '0;
        end
    end

    assign flags.ref_arm = arm_q[SIDE_REF];
    assign flags.fb_arm  = arm_q[SIDE_FB];
endmodule

// File: rtl/pfd_out_map.sv
module pfd_out_map
    import pfd_pkg::*;
(
    input  pfd_cfg_t   cfg,
    input  pfd_flags_t flags,
    output logic       se_oe,
    output logic       se_data,
    output logic       pump_ref_n,
    output logic       pump_fb_n,
    output logic       lock_out
);
    pfd_cmp_e cmp;
    logic     one_sided;

    assign cmp       = classify(flags);
    assign one_sided = is_one_sided(cmp);

    always_comb begin
        se_oe   = cfg.single_sel && one_sided;
        se_data = se_oe && ((cmp == CMP_REF_LEAD) ^ cfg.pol_inv);
    end

    always_comb begin
        if (cfg.single_sel) begin
            pump_ref_n = 1'b1;
            pump_fb_n  = 1'b1;
        end else if (cfg.pol_inv) begin
            pump_ref_n = ~flags.fb_arm;
            pump_fb_n  = ~flags.ref_arm;
        end else begin
            pump_ref_n = ~flags.ref_arm;
            pump_fb_n  = ~flags.fb_arm;
        end
    end

    assign lock_out = cfg.lock_en && !one_sided;
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
    import pfd_pkg::*;
#(
    parameter int unsigned CLR_DELAY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_pulse,
    input  logic fb_pulse,
    input  logic reload,
    input  logic single_sel,
    input  logic pol_inv,
    input  logic lock_en,
    output logic se_oe,
    output logic se_data,
    output logic pump_ref_n,
    output logic pump_fb_n,
    output logic lock_out
);
    pfd_cfg_t             cfg;
    pfd_flags_t           flags;
    logic [NUM_SIDES-1:0] pulses;
    logic                 ref_flag;
    logic                 fb_flag;

    assign cfg.single_sel = single_sel;
    assign cfg.pol_inv    = pol_inv;
    assign cfg.lock_en    = lock_en;

    assign pulses[SIDE_REF] = ref_pulse;
    assign pulses[SIDE_FB]  = fb_pulse;

    pfd_core #(.CLR_DELAY(CLR_DELAY)) u_core (
        .clk      (clk),
        .rst      (rst),
        .reload   (reload),
        .pulse_in (pulses),
        .flags    (flags)
    );

    assign ref_flag = flags.ref_arm;
    assign fb_flag  = flags.fb_arm;

    pfd_out_map u_map (
        .cfg        (cfg),
        .flags      (flags),
        .se_oe      (se_oe),
        .se_data    (se_data),
        .pump_ref_n (pump_ref_n),
        .pump_fb_n  (pump_fb_n),
        .lock_out   (lock_out)
    );
endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk #(
    parameter int unsigned CLR_DELAY = 2
) (
    input logic clk,
    input logic rst,
    input logic reload,
    input logic single_sel,
    input logic lock_en,
    input logic ref_flag,
    input logic fb_flag,
    input logic se_oe,
    input logic pump_ref_n,
    input logic pump_fb_n,
    input logic lock_out
);
    // R8
    pumps_idle_in_single_chk: assert property (@(posedge clk) disable iff (rst)
        single_sel |-> (pump_ref_n && pump_fb_n));

    // R8
    se_off_in_pair_chk: assert property (@(posedge clk) disable iff (rst)
        !single_sel |-> !se_oe);

    // R10
    lock_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !lock_en |-> !lock_out);

    // R9
    lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_en && (ref_flag != fb_flag)) |-> !lock_out);

    // R9
    lock_hold_coincide_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_en && ref_flag && fb_flag) |-> lock_out);

    // R11
    reload_clears_chk: assert property (@(posedge clk) disable iff (rst)
        reload |=> (!ref_flag && !fb_flag));

    if (CLR_DELAY >= 2) begin : g_minw
        // R3
        coincide_min_width_chk: assert property (@(posedge clk) disable iff (rst || reload)
            $rose(ref_flag && fb_flag) |=> (ref_flag && fb_flag));
    end
endmodule

bind pfd_lock_top pfd_lock_chk #(.CLR_DELAY(CLR_DELAY)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reload     (reload),
    .single_sel (single_sel),
    .lock_en    (lock_en),
    .ref_flag   (ref_flag),
    .fb_flag    (fb_flag),
    .se_oe      (se_oe),
    .pump_ref_n (pump_ref_n),
    .pump_fb_n  (pump_fb_n),
    .lock_out   (lock_out)
);

// File: tb/pfd_lock_top_test.sv
module pfd_lock_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int D          = 2;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst, ref_pulse, fb_pulse, reload, single_sel, pol_inv, lock_en;
    logic se_oe, se_data, pump_ref_n, pump_fb_n, lock_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfd_lock_top #(.CLR_DELAY(D)) uut (
        .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
        .reload(reload), .single_sel(single_sel), .pol_inv(pol_inv),
        .lock_en(lock_en), .se_oe(se_oe), .se_data(se_data),
        .pump_ref_n(pump_ref_n), .pump_fb_n(pump_fb_n), .lock_out(lock_out)
    );

    task automatic check_bit(input string name, input string tag,
                             input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b at %0t", tag, name, act, exp, $time);
        end
    endtask

    // Expected outputs derived from the armed state of each side (R4-R10)
    task automatic check_out(input logic erf, input logic eff, input string ctx);
        logic one, x_oe, x_d, x_pr, x_pf, x_lk;
        string se_tag, pp_tag, lk_tag;
        one    = erf ^ eff;
        x_oe   = single_sel & one;
        x_d    = x_oe & (erf ^ pol_inv);
        x_pr   = single_sel ? 1'b1 : (pol_inv ? ~eff : ~erf);
        x_pf   = single_sel ? 1'b1 : (pol_inv ? ~erf : ~eff);
        x_lk   = lock_en & ~one;
        se_tag = !single_sel ? "R8" : (pol_inv ? "R5" : "R4");
        pp_tag = single_sel ? "R8" : (pol_inv ? "R7" : "R6");
        lk_tag = lock_en ? "R9" : "R10";
        check_bit("se_oe",      {ctx, "/", se_tag}, se_oe,      x_oe);
        check_bit("se_data",    {ctx, "/", se_tag}, se_data,    x_d);
        check_bit("pump_ref_n", {ctx, "/", pp_tag}, pump_ref_n, x_pr);
        check_bit("pump_fb_n",  {ctx, "/", pp_tag}, pump_fb_n,  x_pf);
        check_bit("lock_out",   {ctx, "/", lk_tag}, lock_out,   x_lk);
    endtask

    // Drive inputs at a falling edge, return at the next falling edge
    task automatic tick(input logic r, input logic f, input logic rl);
        ref_pulse = r;
        fb_pulse  = f;
        reload    = rl;
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic s, input logic p, input logic l);
        single_sel = s;
        pol_inv    = p;
        lock_en    = l;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ref_pulse = 1'b0; fb_pulse = 1'b0; reload = 1'b0;
        set_cfg(1'b0, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        // R1: idle state during reset
        check_out(1'b0, 1'b0, "R1");
        rst = 1'b0;
        @(negedge clk);
        check_out(1'b0, 1'b0, "R1");

        // Sweep of edge offset against every configuration (R3-R10)
        for (int cfgv = 0; cfgv < 8; cfgv++) begin
            set_cfg(cfgv[2], cfgv[1], cfgv[0]);
            for (int d = -2; d <= 5; d++) begin
                int a, b, m, len;
                a   = 2;
                b   = 2 + d;
                m   = (a > b) ? a : b;
                len = m + D + 2;
                for (int k = 0; k <= len; k++) begin
                    tick(k == a, k == b, 1'b0);
                    // R2 R3: each side armed from its own edge until m+D
                    check_out((k >= a) && (k < m + D), (k >= b) && (k < m + D), "R3");
                end
            end
        end

        set_cfg(1'b0, 1'b0, 1'b1);
        // R2: a held-high input arms its flag only once
        tick(1, 0, 0); check_out(1, 0, "R2");
        tick(1, 0, 0); check_out(1, 0, "R2");
        tick(1, 1, 0); check_out(1, 1, "R2");
        tick(1, 0, 0); check_out(1, 1, "R2");
        tick(1, 0, 0); check_out(0, 0, "R2");
        tick(1, 0, 0); check_out(0, 0, "R2");
        tick(0, 0, 0); check_out(0, 0, "R2");

        // R11: reload clears, and an edge in the reload cycle is lost
        tick(1, 0, 0); check_out(1, 0, "R11");
        tick(0, 0, 0); check_out(1, 0, "R11");
        tick(0, 1, 1); check_out(0, 0, "R11");
        tick(0, 0, 0); check_out(0, 0, "R11");
        tick(0, 0, 0); check_out(0, 0, "R11");
        tick(1, 1, 0); check_out(1, 1, "R11");
        tick(0, 0, 0); check_out(1, 1, "R11");
        tick(0, 0, 0); check_out(0, 0, "R11");

        // R11: reload during a coincident pair
        tick(1, 1, 0); check_out(1, 1, "R11");
        tick(0, 0, 1); check_out(0, 0, "R11");
        tick(0, 0, 0); check_out(0, 0, "R11");

        // R12: edge on the clearing edge of a coincident pair is kept
        tick(1, 1, 0); check_out(1, 1, "R12");
        tick(0, 0, 0); check_out(1, 1, "R12");
        tick(1, 0, 0); check_out(1, 0, "R12");
        tick(0, 0, 0); check_out(1, 0, "R12");
        tick(0, 1, 0); check_out(1, 1, "R12");
        tick(0, 0, 0); check_out(1, 1, "R12");
        tick(0, 0, 0); check_out(0, 0, "R12");

        // R1: reset clears an armed flag
        tick(0, 1, 0); check_out(0, 1, "R1");
        rst = 1'b1;
        tick(0, 0, 0); check_out(0, 0, "R1");
        rst = 1'b0;
        tick(0, 0, 0); check_out(0, 0, "R1");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule